// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block sits in a stereo PCM data path. For each frame it applies one common gain to the left and right samples. The gain follows an 8-bit attenuation code in which 255 is unity, 0 is silence, and each code in between is 0.5 dB below the one above it.

Mute can be requested from an external pin or from a control bit. While mute is requested, the code walks toward 0 one code at a time. Once the request clears, the code walks back toward the programmed target at the same pace. A request withdrawn part-way through a fade turns the walk around at the code it has reached. A new target, set while unmuted, is reached in the same stepwise manner.

The code only moves on frame strobes, so the two channels of any frame always share one gain. Each output is the signed sample times the unsigned gain, rounded and cut back to the sample width.

Top module: `soft_mute_ramp`

## Requirements
- R1: Mute is requested whenever `mute_pin` is 1 or `mute_bit` is 1. With either source high, the code never rises.
- R2: While muting, the code drops by exactly one every STEP_FRAMES (default 4) frame strobes and never jumps.
- R3: A fade from code N down to 0 takes N×STEP_FRAMES strobes. From 255 this is 1020 strobes.
- R4: Once the request is removed, the code climbs by one every STEP_FRAMES strobes until it equals `target_code`, then holds there.
- R5: A request withdrawn before the code reaches 0 reverses the walk from the current code. The strobe count in progress carries on and is not restarted.
- R6: While unmuted, a change of `target_code` is approached one code per STEP_FRAMES strobes. When the code equals its goal, the step count is cleared and the code holds.
- R7: The code and both outputs change only on the clock edge where `frame_stb` is 1. Outputs show the product of that edge's samples and the gain of the code held before that edge.
- R8: Gain uses k = 255 − code: gain = round(32768·2^(−(k mod 12)/12)) >> (k div 12). Code 0 gives gain 0.
- R9: Each output = (sample·gain + 16384) >>> 15, truncated to SAMPLE_W bits. At code 255 the sample passes unchanged. At code 0 the output is exactly 0.
- R10: Synchronous active-low reset loads the code from `target_code`, clears the step count and sets both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe per stereo frame |
| mute_pin | input | 1 | External mute request |
| mute_bit | input | 1 | Register mute request |
| target_code | input | 8 | Programmed attenuation code (255 = 0 dB) |
| in_l | input | SAMPLE_W | Left signed sample |
| in_r | input | SAMPLE_W | Right signed sample |
| out_l | output | SAMPLE_W | Left attenuated sample |
| out_r | output | SAMPLE_W | Right attenuated sample |

## Verification
The internal code is observable only through the outputs, one clock after each strobe.

A wrong code shows up as a wrong product on the very next frame whose sample is large enough to resolve a 0.5 dB step. A step counter that is off by one surfaces within one step period as a gain change on the wrong frame.

Reversal, the end of a fade and holding at the target are each driven past, so a misplaced turnaround or an overshoot shows up within a few frames of the event.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;

    localparam int CODE_W   = 8;
    localparam int GAIN_W   = 16;
    localparam int FRAC_SH  = GAIN_W - 1;
    localparam int PER_OCT  = 12;
    localparam int CODE_TOP = (1 << CODE_W) - 1;

    // Unity-referenced mantissa for one twelfth-octave position
    function automatic logic [GAIN_W-1:0] octave_mant(input logic [3:0] pos);
        logic [GAIN_W-1:0] m;
        case (pos)
            4'd0:    m = 16'd32768;
            4'd1:    m = 16'd30929;
            4'd2:    m = 16'd29193;
            4'd3:    m = 16'd27554;
            4'd4:    m = 16'd26008;
            4'd5:    m = 16'd24548;
            4'd6:    m = 16'd23170;
            4'd7:    m = 16'd21870;
            4'd8:    m = 16'd20643;
            4'd9:    m = 16'd19484;
            4'd10:   m = 16'd18390;
            4'd11:   m = 16'd17358;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/soft_mute_step_ctrl.sv
module soft_mute_step_ctrl
    import soft_mute_pkg::*;
#(
    parameter int STEP_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute_req,
    input  logic [CODE_W-1:0] target_code,
    output logic [CODE_W-1:0] code_q
);
    localparam int CNT_W = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_FRAMES - 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
    } ramp_t;

    ramp_t st_d, st_q;
    logic [CODE_W-1:0] goal;

    always_comb begin
        goal = mute_req ? '0 : target_code;
        st_d = st_q;
        if (frame_stb) begin
            if (st_q.code == goal) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CNT_LAST) begin
                st_d.cnt  = '0;
                st_d.code = (goal > st_q.code) ? st_q.code + 1'b1 : st_q.code - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= target_code;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q = st_q.code;

endmodule

// File: rtl/soft_mute_gain_lut.sv
module soft_mute_gain_lut
    import soft_mute_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);
    logic [CODE_W-1:0] depth;
    logic [CODE_W-1:0] octave;
    logic [CODE_W-1:0] pos;

    always_comb begin
        depth  = CODE_W'(CODE_TOP) - code;
        octave = depth / CODE_W'(PER_OCT);
        pos    = depth % CODE_W'(PER_OCT);
        if (code == '0) begin
            gain = '0;
        end else if (octave >= CODE_W'(GAIN_W)) begin
            gain = '0;
        end else begin
            gain = octave_mant(pos[3:0]) >> octave;
        end
    end

endmodule

// File: rtl/soft_mute_mult.sv
module soft_mute_mult
    import soft_mute_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_stb,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W-1:0]          gain,
    output logic signed [SAMPLE_W-1:0] y_q
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_SH - 1);

    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   rounded;
    logic signed [SAMPLE_W-1:0] y_d;

    always_comb begin
        prod    = PROD_W'(sample) * $signed({1'b0, gain});
        rounded = (prod + HALF) >>> FRAC_SH;
        y_d     = frame_stb ? rounded[SAMPLE_W-1:0] : y_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q <= '0;
        end else begin
            y_q <= y_d;
        end
    end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
    import soft_mute_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int STEP_FRAMES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_stb,
    input  logic                       mute_pin,
    input  logic                       mute_bit,
    input  logic [CODE_W-1:0]          target_code,
    input  logic signed [SAMPLE_W-1:0] in_l,
    input  logic signed [SAMPLE_W-1:0] in_r,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r
);
    localparam int NUM_CH = 2;

    logic                mute_req;
    logic [CODE_W-1:0]   ramp_code;
    logic [GAIN_W-1:0]   gain;
    logic signed [SAMPLE_W-1:0] ch_in  [NUM_CH];
    logic signed [SAMPLE_W-1:0] ch_out [NUM_CH];

    assign mute_req = mute_pin | mute_bit;

    soft_mute_step_ctrl #(
        .STEP_FRAMES(STEP_FRAMES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .mute_req   (mute_req),
        .target_code(target_code),
        .code_q     (ramp_code)
    );

    soft_mute_gain_lut u_lut (
        .code(ramp_code),
        .gain(gain)
    );

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        soft_mute_mult #(
            .SAMPLE_W(SAMPLE_W)
        ) u_mult (
            .clk      (clk),
            .rst_n    (rst_n),
            .frame_stb(frame_stb),
            .sample   (ch_in[c]),
            .gain     (gain),
            .y_q      (ch_out[c])
        );
    end

    assign out_l = ch_out[0];
    assign out_r = ch_out[1];

endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk
    import soft_mute_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_stb,
    input logic                       mute_pin,
    input logic                       mute_bit,
    input logic [CODE_W-1:0]          target_code,
    input logic [CODE_W-1:0]          code,
    input logic signed [SAMPLE_W-1:0] in_l,
    input logic signed [SAMPLE_W-1:0] out_l,
    input logic signed [SAMPLE_W-1:0] out_r
);
    AST_MUTE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mute_pin || mute_bit) && frame_stb) |=> (code <= $past(code))); // R1

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((code == $past(code)) || (code == $past(code) + 8'd1)
                          || (code == $past(code) - 8'd1))); // R2

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(code) && $stable(out_l) && $stable(out_r))); // R7

    AST_GOAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_pin && !mute_bit && frame_stb && code == target_code) |=> $stable(code)); // R6

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && code == '0) |=> (out_l == '0 && out_r == '0)); // R9

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && code == 8'd255) |=> (out_l == $past(in_l))); // R9

endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .mute_pin   (mute_pin),
    .mute_bit   (mute_bit),
    .target_code(target_code),
    .code       (ramp_code),
    .in_l       (in_l),
    .out_l      (out_l),
    .out_r      (out_r)
);

// File: tb/sim_soft_mute_ramp.sv
`timescale 1ns/1ps
module sim_soft_mute_ramp;
    localparam int SW = 24;
    localparam int SF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic mute_pin = 1'b0;
    logic mute_bit = 1'b0;
    logic [7:0] target_code = 8'd255;
    logic signed [SW-1:0] in_l = '0;
    logic signed [SW-1:0] in_r = '0;
    logic signed [SW-1:0] out_l, out_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string tag = "R10";

    int m_code = 255;
    int m_cnt = 0;
    logic signed [SW-1:0] m_l = '0;
    logic signed [SW-1:0] m_r = '0;

    always #4 clk = ~clk;

    soft_mute_ramp #(.SAMPLE_W(SW), .STEP_FRAMES(SF)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .mute_pin(mute_pin), .mute_bit(mute_bit), .target_code(target_code),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
    );

    // R8: gain from code, computed with real arithmetic
    function automatic longint gain_of(int c);
        int k;
        real r;
        longint g;
        if (c == 0) return 0;
        k = 255 - c;
        r = 32768.0 * (2.0 ** (-(k % 12) / 12.0));
        g = longint'($rtoi(r + 0.5));
        return g >> (k / 12);
    endfunction

    // R9: rounded product truncated to sample width
    function automatic logic signed [SW-1:0] scale(logic signed [SW-1:0] x, int c);
        longint p;
        p = longint'(x) * gain_of(c) + 64'sd16384;
        p = p >>> 15;
        return p[SW-1:0];
    endfunction

    always @(posedge clk) begin
        int goal;
        if (!rst_n) begin
            m_code = int'(target_code);
            m_cnt = 0;
            m_l = '0;
            m_r = '0;
        end else if (frame_stb) begin
            m_l = scale(in_l, m_code);
            m_r = scale(in_r, m_code);
            goal = (mute_pin || mute_bit) ? 0 : int'(target_code);
            if (m_code == goal) m_cnt = 0;
            else if (m_cnt == SF - 1) begin
                m_cnt = 0;
                m_code = (goal > m_code) ? m_code + 1 : m_code - 1;
            end else m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_l !== m_l || out_r !== m_r) begin
                failures++;
                $display("FAIL %s: out_l=%0d out_r=%0d expected %0d %0d (model code %0d)",
                         tag, out_l, out_r, m_l, m_r, m_code);
            end
        end
    end

    task automatic frames(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = 1'b1;
            in_l = SW'($urandom);
            in_r = SW'($urandom);
            @(negedge clk);
            frame_stb = 1'b0;
            in_l = SW'($urandom);
            in_r = SW'($urandom);
        end
    endtask

    task automatic expect_eq(string req, logic signed [SW-1:0] a, logic signed [SW-1:0] e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, a, e);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_eq("R10", out_l, '0);
        rst_n = 1'b1;
        tag = "R9 unity";
        frames(20);
        @(negedge clk);
        frame_stb = 1'b1; in_l = 24'sh7FFFFF; in_r = -24'sh800000;
        @(negedge clk);
        frame_stb = 1'b0;
        expect_eq("R9", out_l, 24'sh7FFFFF);
        expect_eq("R9", out_r, -24'sh800000);
        tag = "R2 R3 pin fade";
        mute_pin = 1'b1;
        frames(1019);
        tag = "R3 fade end";
        frames(12);
        @(negedge clk);
        frame_stb = 1'b1; in_l = 24'sh400000; in_r = -24'sh123456;
        @(negedge clk);
        frame_stb = 1'b0;
        expect_eq("R3", out_l, '0);
        expect_eq("R9", out_r, '0);
        tag = "R4 release";
        mute_pin = 1'b0;
        frames(1030);
        tag = "R1 bit mute";
        mute_bit = 1'b1;
        frames(150);
        tag = "R5 reversal";
        @(negedge clk);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        mute_bit = 1'b0;
        frames(160);
        tag = "R6 target";
        target_code = 8'd200;
        frames(240);
        target_code = 8'd230;
        frames(130);
        tag = "R7 quiet";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_l = SW'($urandom);
            in_r = SW'($urandom);
        end
        tag = "R1 both";
        mute_pin = 1'b1; mute_bit = 1'b1;
        frames(30);
        mute_pin = 1'b0;
        frames(30);
        mute_bit = 1'b0;
        frames(20);
        tag = "R10 reset";
        @(negedge clk);
        rst_n = 1'b0;
        target_code = 8'd100;
        @(negedge clk);
        expect_eq("R10", out_l, '0);
        expect_eq("R10", out_r, '0);
        rst_n = 1'b1;
        tag = "R8 gain";
        frames(10);
        @(negedge clk);
        frame_stb = 1'b1; in_l = 24'sh100000; in_r = 24'sh100000;
        @(negedge clk);
        frame_stb = 1'b0;
        expect_eq("R8", out_l, scale(24'sh100000, 100));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule